// File: doc/BRIEF.md
# Staged-Register Instruction Cycle Sequencer

This block steps a processor through one instruction at a time in six ordered phases: instruction fetch, decode, operand fetch, execute, result store and next-instruction selection. Every access to the synchronous single-port memory goes through two staging registers. An address register is the only source of the memory address. A data register receives every word the memory returns and supplies every word written to it. No other register ever talks to the memory directly.

The program counter is copied into the address register before a fetch. The returned word lands in the data register, then moves into the instruction register. External decode logic looks at the instruction register. It tells the sequencer whether an operand read is needed, whether a result write is needed, the data address, and whether to branch and where. External execute logic returns a result computed from the data register. The operand and store phases are skipped when the decode hook does not ask for them. A halt input parks the sequencer in the next-instruction phase.

Top module: `mdr_fetch_seq`

## Requirements
- R1: A synchronous active-low reset clears the program counter, address register, data register and instruction register to zero. It puts the sequencer in the fetch phase with no memory request.
- R2: A fetch spends one cycle copying the program counter into the address register. The next cycle issues a read request. Whenever a request is active, the memory address equals the address register.
- R3: Read data is taken only into the data register, on the cycle after the read request (one-cycle memory latency). The fetched word moves from the data register into the instruction register during the decode phase.
- R4: `phase_o` reports fetch=0, decode=1, operand=2, execute=3, store=4, next=5. It never takes another value, and the phases of one instruction follow that order. Fetch lasts 3 cycles, decode 1, operand 1 or 3, execute 1, store 0 or 2, and next at least 1.
- R5: When the read flag is set, the operand phase loads the data address into the address register, issues one read, and latches the returned word into the data register. The bench's decode hook takes the read flag from IR bit 15, the write flag from bit 14, the branch flag from bit 13, and the data address and branch target from bits 7:0.
- R6: When the read flag is clear, the operand phase lasts one cycle and makes no memory request. The data register keeps the fetched instruction.
- R7: The execute phase lasts one cycle and loads the execute-result input into the data register.
- R8: When the write flag is set, the store phase loads the data address into the address register. It then issues exactly one write of the data register at that address. Write enable is never active outside this phase. With the flag clear, the store phase is skipped.
- R9: The program counter changes only in the next phase. It becomes the branch target when the branch flag is set, and otherwise the old value plus one, wrapping modulo 2^AW.
- R10: While halt is high in the next phase, the sequencer stays in that phase with no request and an unchanged program counter. It resumes once halt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_i | input | 1 | Hold in the next-instruction phase |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable (with request) |
| mem_addr_o | output | AW | Memory address, from address register |
| mem_wdata_o | output | DW | Write data, from data register |
| mem_rdata_i | input | DW | Read data, valid one cycle after a read request |
| dec_need_rd_i | input | 1 | Decoded instruction needs an operand read |
| dec_need_wr_i | input | 1 | Decoded instruction needs a result write |
| dec_branch_i | input | 1 | Take the branch target as next program counter |
| dec_addr_i | input | AW | Data address for operand read / result write |
| dec_target_i | input | AW | Branch target |
| exe_data_i | input | DW | Execute result, loaded into the data register |
| pc_o | output | AW | Program counter |
| mar_o | output | AW | Address register |
| mdr_o | output | DW | Data register |
| ir_o | output | DW | Instruction register |
| phase_o | output | 3 | Current phase code |

## Verification
The bench runs a program that mixes four kinds of instructions: read-only, write-only, read-and-write, and plain. A design that issued a write with no write request, or left out the skip, would break the cycle-exact request pattern. A result is written and later fetched back as an instruction. A design that wrote the wrong register, or read through the program counter instead of the address register, would fetch the wrong word. A branch to the last address checks the program counter wrap, where a design with a wrong width or a missing wrap would step off the map. A multi-cycle halt and a reset in the middle of a run show whether the program counter drifts or the registers fail to clear.

// File: rtl/fseq_pkg.sv
// Package: shared step/phase encodings and the per-step control word
// for the staged-register instruction cycle sequencer.
package fseq_pkg;

    // Reported phase, one code per instruction-cycle phase
    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_OPER   = 3'd2,
        PH_EXEC   = 3'd3,
        PH_STORE  = 3'd4,
        PH_NEXT   = 3'd5
    } phase_e;

    // Internal step, several per phase where memory needs them
    typedef enum logic [3:0] {
        ST_IF_ADDR,
        ST_IF_READ,
        ST_IF_LATCH,
        ST_ID,
        ST_OF_ADDR,
        ST_OF_READ,
        ST_OF_LATCH,
        ST_EX,
        ST_RS_ADDR,
        ST_RS_WRITE,
        ST_NX
    } step_e;

    // Register load and memory strobes for one step
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_dec;
        logic mdr_from_mem;
        logic mdr_from_exe;
        logic ir_load;
        logic pc_advance;
        logic mem_read;
        logic mem_write;
    } ctl_t;

    // Map an internal step to its reported phase
    function automatic phase_e phase_of(step_e s);
        case (s)
            ST_IF_ADDR, ST_IF_READ, ST_IF_LATCH: phase_of = PH_FETCH;
            ST_ID:                               phase_of = PH_DECODE;
            ST_OF_ADDR, ST_OF_READ, ST_OF_LATCH: phase_of = PH_OPER;
            ST_EX:                               phase_of = PH_EXEC;
            ST_RS_ADDR, ST_RS_WRITE:             phase_of = PH_STORE;
            default:                             phase_of = PH_NEXT;
        endcase
    endfunction

endpackage

// File: rtl/fseq_ctrl.sv
// Module: fseq_ctrl
// Step sequencer. Walks the fixed step order and skips the operand
// steps when no read is needed and the store steps when no write is
// needed. Parks in the next step while halt is high.
// Assumes: the decode flags are valid from the cycle after the
// instruction register loads, and the memory has one-cycle read latency.
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt_i,
    input  logic   need_rd_i,
    input  logic   need_wr_i,
    output ctl_t   ctl_o,
    output phase_e phase_o
);

    step_e step_q, step_d;

    // Step register, reset to the first fetch step
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IF_ADDR;
        else        step_q <= step_d;
    end

    // Next-step selection including operand/store skips and halt
    always_comb begin
        case (step_q)
            ST_IF_ADDR:  step_d = ST_IF_READ;
            ST_IF_READ:  step_d = ST_IF_LATCH;
            ST_IF_LATCH: step_d = ST_ID;
            ST_ID:       step_d = ST_OF_ADDR;
            ST_OF_ADDR:  step_d = need_rd_i ? ST_OF_READ : ST_EX;
            ST_OF_READ:  step_d = ST_OF_LATCH;
            ST_OF_LATCH: step_d = ST_EX;
            ST_EX:       step_d = need_wr_i ? ST_RS_ADDR : ST_NX;
            ST_RS_ADDR:  step_d = ST_RS_WRITE;
            ST_RS_WRITE: step_d = ST_NX;
            ST_NX:       step_d = halt_i ? ST_NX : ST_IF_ADDR;
            default:     step_d = ST_IF_ADDR;
        endcase
    end

    // Control word decode for the current step
    always_comb begin
        ctl_o = '0;
        case (step_q)
            ST_IF_ADDR:  ctl_o.mar_from_pc  = 1'b1;
            ST_IF_READ:  ctl_o.mem_read     = 1'b1;
            ST_IF_LATCH: ctl_o.mdr_from_mem = 1'b1;
            ST_ID:       ctl_o.ir_load      = 1'b1;
            ST_OF_ADDR:  ctl_o.mar_from_dec = need_rd_i;
            ST_OF_READ:  ctl_o.mem_read     = 1'b1;
            ST_OF_LATCH: ctl_o.mdr_from_mem = 1'b1;
            ST_EX:       ctl_o.mdr_from_exe = 1'b1;
            ST_RS_ADDR:  ctl_o.mar_from_dec = 1'b1;
            ST_RS_WRITE: ctl_o.mem_write    = 1'b1;
            ST_NX:       ctl_o.pc_advance   = !halt_i;
            default:     ctl_o = '0;
        endcase
    end

    // Reported phase
    assign phase_o = phase_of(step_q);

endmodule

// File: rtl/fseq_regs.sv
// Module: fseq_regs
// Programmer-visible and staging registers: PC, MAR, MDR, IR.
// Assumes: at most one load source is active per register in a step
// (guaranteed by fseq_ctrl). The PC wraps modulo 2^AW.
module fseq_regs
    import fseq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int PC_STEP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl_i,
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] exe_i,
    input  logic [AW-1:0] dec_addr_i,
    input  logic          branch_i,
    input  logic [AW-1:0] target_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] mar_o,
    output logic [DW-1:0] mdr_o,
    output logic [DW-1:0] ir_o
);

    localparam logic [AW-1:0] PC_INC = AW'(PC_STEP);

    // Program counter: advances or branches in the next step only
    always_ff @(posedge clk) begin
        if (!rst_n)                pc_o <= '0;
        else if (ctl_i.pc_advance) pc_o <= branch_i ? target_i : pc_o + PC_INC;
    end

    // Address register: sole source of memory address
    always_ff @(posedge clk) begin
        if (!rst_n)                  mar_o <= '0;
        else if (ctl_i.mar_from_pc)  mar_o <= pc_o;
        else if (ctl_i.mar_from_dec) mar_o <= dec_addr_i;
    end

    // Data register: sole receiver of read data and source of write data
    always_ff @(posedge clk) begin
        if (!rst_n)                  mdr_o <= '0;
        else if (ctl_i.mdr_from_mem) mdr_o <= rdata_i;
        else if (ctl_i.mdr_from_exe) mdr_o <= exe_i;
    end

    // Instruction register: loaded from the data register at decode
    always_ff @(posedge clk) begin
        if (!rst_n)             ir_o <= '0;
        else if (ctl_i.ir_load) ir_o <= mdr_o;
    end

endmodule

// File: rtl/fseq_memif.sv
// Module: fseq_memif
// Memory port drive. Address and write data come straight from the
// staging registers; request and write enable come from the step strobes.
// Assumes: a synchronous single-port memory that samples on the clock edge.
module fseq_memif
    import fseq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  ctl_t          ctl_i,
    input  logic [AW-1:0] mar_i,
    input  logic [DW-1:0] mdr_i,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);

    // Port strobes and staging-register drive
    always_comb begin
        req_o   = ctl_i.mem_read | ctl_i.mem_write;
        we_o    = ctl_i.mem_write;
        addr_o  = mar_i;
        wdata_o = mdr_i;
    end

endmodule

// File: rtl/mdr_fetch_seq.sv
// Module: mdr_fetch_seq (top)
// Six-phase instruction cycle sequencer in which all memory traffic is
// staged through an address register and a data register.
// Assumes: external decode/execute logic observes ir_o/mdr_o and returns
// flags, addresses and the execute result combinationally.
module mdr_fetch_seq
    import fseq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int PC_STEP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          dec_need_rd_i,
    input  logic          dec_need_wr_i,
    input  logic          dec_branch_i,
    input  logic [AW-1:0] dec_addr_i,
    input  logic [AW-1:0] dec_target_i,
    input  logic [DW-1:0] exe_data_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] mar_o,
    output logic [DW-1:0] mdr_o,
    output logic [DW-1:0] ir_o,
    output logic [2:0]    phase_o
);

    ctl_t   ctl;
    phase_e phase;

    fseq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_i),
        .need_rd_i (dec_need_rd_i),
        .need_wr_i (dec_need_wr_i),
        .ctl_o     (ctl),
        .phase_o   (phase)
    );

    fseq_regs #(.AW(AW), .DW(DW), .PC_STEP(PC_STEP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (ctl),
        .rdata_i    (mem_rdata_i),
        .exe_i      (exe_data_i),
        .dec_addr_i (dec_addr_i),
        .branch_i   (dec_branch_i),
        .target_i   (dec_target_i),
        .pc_o       (pc_o),
        .mar_o      (mar_o),
        .mdr_o      (mdr_o),
        .ir_o       (ir_o)
    );

    fseq_memif #(.AW(AW), .DW(DW)) u_memif (
        .ctl_i   (ctl),
        .mar_i   (mar_o),
        .mdr_i   (mdr_o),
        .req_o   (mem_req_o),
        .we_o    (mem_we_o),
        .addr_o  (mem_addr_o),
        .wdata_o (mem_wdata_o)
    );

    assign phase_o = phase;

endmodule

// File: rtl/fseq_chk.sv
// Module: fseq_chk
// Protocol checker bound to mdr_fetch_seq. Observes ports only.
// Assumes: reset is held for at least two clock edges.
module fseq_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt_i,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_rdata_i,
    input logic [AW-1:0] pc_o,
    input logic [AW-1:0] mar_o,
    input logic [DW-1:0] mdr_o,
    input logic [DW-1:0] ir_o,
    input logic [2:0]    phase_o
);

    // R1: registers are clear and phase is fetch on the first cycle out of reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_o == '0 && mar_o == '0 && mdr_o == '0 &&
                          ir_o == '0 && phase_o == 3'd0 && !mem_req_o));

    // R2: the memory address comes only from the address register
    a_r2_addr_from_mar: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o == mar_o));

    // R3: read data reaches the data register one cycle after the request
    a_r3_mdr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> ##1 (mdr_o == $past(mem_rdata_i)));

    // R3: the instruction register only ever takes the data register value
    a_r3_ir_from_mdr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ir_o) |-> (ir_o == $past(mdr_o)));

    // R4: phase code is always a legal value
    a_r4_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o <= 3'd5);

    // R8: write enable only with a request in the store phase
    a_r8_write_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_req_o && phase_o == 3'd4));

    // R9: the program counter moves only out of the next phase
    a_r9_pc_only_next: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |-> ($past(phase_o) == 3'd5));

    // R10: halt holds the next phase and the program counter
    a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd5 && halt_i) |=> (phase_o == 3'd5 && $stable(pc_o) && !mem_req_o));

endmodule

bind mdr_fetch_seq fseq_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_i      (halt_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .pc_o        (pc_o),
    .mar_o       (mar_o),
    .mdr_o       (mdr_o),
    .ir_o        (ir_o),
    .phase_o     (phase_o)
);

// File: tb/mdr_fetch_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural memory, behavioural decode hook, and a per-instruction
// reference that lists the expected port values for every cycle.
module mdr_fetch_seq_tb_top;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_i = 1'b0;
    logic          mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          dec_need_rd_i, dec_need_wr_i, dec_branch_i;
    logic [AW-1:0] dec_addr_i, dec_target_i;
    logic [DW-1:0] exe_data_i;
    logic [AW-1:0] pc_o, mar_o;
    logic [DW-1:0] mdr_o, ir_o;
    logic [2:0]    phase_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] mem     [256];
    logic [DW-1:0] ref_mem [256];
    logic [AW-1:0] ref_pc;

    always #2.5 clk = ~clk;

    mdr_fetch_seq #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .dec_need_rd_i(dec_need_rd_i), .dec_need_wr_i(dec_need_wr_i),
        .dec_branch_i(dec_branch_i), .dec_addr_i(dec_addr_i),
        .dec_target_i(dec_target_i), .exe_data_i(exe_data_i),
        .pc_o(pc_o), .mar_o(mar_o), .mdr_o(mdr_o), .ir_o(ir_o), .phase_o(phase_o)
    );

    // Decode hook: bit15 read, bit14 write, bit13 branch, bits 7:0 address/target
    assign dec_need_rd_i = ir_o[15];
    assign dec_need_wr_i = ir_o[14];
    assign dec_branch_i  = ir_o[13];
    assign dec_addr_i    = ir_o[7:0];
    assign dec_target_i  = ir_o[7:0];
    assign exe_data_i    = mdr_o + 16'h0101;

    // Synchronous memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
            else          mem_rdata_i <= mem[mem_addr_o];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Idle cycle: phase and no request
    task automatic idle(input string tag, input logic [2:0] ph);
        chk({tag, " phase"}, 32'(phase_o), 32'(ph));
        chk({tag, " no req"}, 32'(mem_req_o), 32'd0);
    endtask

    // Reference run of one instruction, checked every cycle
    task automatic run_one(input int hold);
        logic [DW-1:0] ins, opnd, res;
        logic [AW-1:0] a;
        ins = ref_mem[ref_pc];
        a = ins[7:0];
        halt_i = (hold > 0);
        // fetch: address cycle
        idle("R4 fetch addr", 3'd0);
        chk("R9 pc at fetch", 32'(pc_o), 32'(ref_pc));
        step();
        // fetch: read cycle
        chk("R4 fetch read phase", 32'(phase_o), 32'd0);
        chk("R2 fetch req", {mem_req_o, mem_we_o}, 32'b10);
        chk("R2 fetch addr", 32'(mem_addr_o), 32'(ref_pc));
        chk("R2 mar=pc", 32'(mar_o), 32'(ref_pc));
        step();
        idle("R3 fetch latch", 3'd0);
        step();
        idle("R4 decode", 3'd1);
        chk("R3 mdr holds instr", 32'(mdr_o), 32'(ins));
        step();
        idle("R6 operand entry", 3'd2);
        chk("R3 ir from mdr", 32'(ir_o), 32'(ins));
        opnd = ins;
        step();
        if (ins[15]) begin
            chk("R5 operand phase", 32'(phase_o), 32'd2);
            chk("R5 operand req", {mem_req_o, mem_we_o}, 32'b10);
            chk("R5 operand addr", 32'(mem_addr_o), 32'(a));
            step();
            idle("R5 operand latch", 3'd2);
            step();
            opnd = ref_mem[a];
        end
        idle("R7 execute", 3'd3);
        chk(ins[15] ? "R5 operand in mdr" : "R6 mdr keeps instr", 32'(mdr_o), 32'(opnd));
        res = opnd + 16'h0101;
        step();
        if (ins[14]) begin
            idle("R8 store addr", 3'd4);
            chk("R7 result in mdr", 32'(mdr_o), 32'(res));
            step();
            chk("R8 store phase", 32'(phase_o), 32'd4);
            chk("R8 write req", {mem_req_o, mem_we_o}, 32'b11);
            chk("R8 write addr", 32'(mem_addr_o), 32'(a));
            chk("R8 write data", 32'(mem_wdata_o), 32'(res));
            ref_mem[a] = res;
            step();
        end else begin
            chk("R7 result in mdr", 32'(mdr_o), 32'(res));
        end
        for (int k = 0; k < ((hold > 0) ? hold : 1); k++) begin
            idle(hold > 0 ? "R10 halted next" : "R4 next", 3'd5);
            chk(hold > 0 ? "R10 pc held" : "R9 pc before next", 32'(pc_o), 32'(ref_pc));
            if (k == hold - 1) halt_i = 1'b0;
            step();
        end
        ref_pc = ins[13] ? a : ref_pc + 8'd1;
    endtask

    task automatic reset_check();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 pc", 32'(pc_o), 32'd0);
        chk("R1 mar", 32'(mar_o), 32'd0);
        chk("R1 mdr", 32'(mdr_o), 32'd0);
        chk("R1 ir", 32'(ir_o), 32'd0);
        chk("R1 phase", 32'(phase_o), 32'd0);
        chk("R1 no req", 32'(mem_req_o), 32'd0);
        rst_n = 1'b1;
        ref_pc = '0;
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Program and stimulus
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h00] = 16'h0000;   // plain
        mem[8'h01] = 16'h8040;   // read 0x40
        mem[8'h02] = 16'h4050;   // write 0x50
        mem[8'h03] = 16'hC041;   // read and write 0x41
        mem[8'h04] = 16'h2010;   // branch 0x10
        mem[8'h10] = 16'h8050;   // read back written word
        mem[8'h11] = 16'hE020;   // read/write 0x20, branch there (self-modify)
        mem[8'h20] = 16'hA5A5;
        mem[8'h40] = 16'h1234;
        mem[8'h41] = 16'h00FF;
        mem[8'hA7] = 16'h20FF;   // branch to last address
        for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
        @(negedge clk);
        #1;
        reset_check();
        for (int n = 0; n < 14; n++) run_one(n == 3 ? 4 : 0);
        reset_check();
        run_one(0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule